// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block takes in a three-wire serial audio stream (bit clock, word clock and serial data) and turns it into parallel stereo PCM samples. It handles right-justified framing: each sample is sent most-significant bit first and ends at the word-clock transition. The last bit of a sample is its LSB, and it is the last bit sampled before the word clock changes level. The word clock is high for the left channel and low for the right channel. When the right sample of a frame is complete, both samples appear at once on the outputs with a one-cycle valid strobe.

The three serial wires are brought into the system clock domain through synchronisers, and bit-clock edges are detected there. The system clock must run at least four times faster than the bit clock. The block has four configuration inputs:
- an interface mode code, of which only one value enables the receiver;
- a word-length code;
- a bit-clock offset that moves the sample window after the word-clock edge;
- an inversion control that picks which bit-clock edge samples the data.

A frame-length check flags frames that are too short to hold two samples of the programmed length.

Top module: `rj_audio_rx`

## Requirements
- R1: The receiver operates only when `cfg_mode` equals 2'b10. With any other code, `out_valid` stays low and no sample reaches the outputs.
- R2: Bits are shifted in MSB first. The left sample ends with the bit taken on the last active bit-clock edge while the word clock is high (just before the word clock falls).
- R3: The right sample ends with the bit taken on the last active edge while the word clock is low (just before the word clock rises). Once it is captured, the left and right samples of that frame are presented together with `out_valid`.
- R4: `cfg_wlen` selects the word length: 2'b00 = 16 bits, 2'b01 = 20 bits, 2'b10 = 24 bits, 2'b11 = 32 bits. Each output is the sample sign-extended to 32 bits. Filler bits ahead of a shorter sample are discarded.
- R5: With `cfg_offset` = K, every sample ends K active edges later than it does with K = 0. K must be smaller than half a frame.
- R6: With `cfg_bclk_inv` = 0, data and word clock are sampled on the rising edge of `ser_bclk`. With `cfg_bclk_inv` = 1, they are sampled on the falling edge.
- R7: A frame is counted in active edges from one rising word-clock transition to the next. At the end of each frame after the first, `frame_err` is set if the frame was shorter than twice the word length, and cleared otherwise.
- R8: Reset, or any mode code other than 2'b10, clears `out_left`, `out_right`, `out_valid` and `frame_err`.
- R9: `out_valid` is high for exactly one system clock per frame. `out_left` and `out_right` keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Interface mode code; 2'b10 enables the receiver |
| cfg_wlen | input | 2 | Word-length code (16/20/24/32 bits) |
| cfg_offset | input | OFS_W | Sample-end offset in bit clocks |
| cfg_bclk_inv | input | 1 | Sample on the falling bit-clock edge when 1 |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_wclk | input | 1 | Serial word clock, high for the left channel |
| ser_data | input | 1 | Serial data |
| out_left | output | 32 | Sign-extended left sample |
| out_right | output | 32 | Sign-extended right sample |
| out_valid | output | 1 | One-cycle strobe marking a new stereo pair |
| frame_err | output | 1 | Last complete frame was shorter than two words |

## Verification
The assertions assume the configuration inputs are held steady while the receiver is enabled, and that word clock and data change only away from the active bit-clock edge. They also assume each half-frame lasts many system clocks, so two valid strobes can never fall on adjacent cycles. The stimulus meets these assumptions as follows:
- It changes the configuration only while the mode code is idle, and idles the mode between scenarios.
- It changes data and word clock together at the inactive bit-clock edge.
- It gives every bit period eight system clocks.

// File: rtl/rj_rx_pkg.sv
package rj_rx_pkg;

  localparam int SAMPLE_W = 32;
  localparam logic [1:0] MODE_RJ = 2'b10;

  typedef enum logic [1:0] {
    WL16 = 2'b00,
    WL20 = 2'b01,
    WL24 = 2'b10,
    WL32 = 2'b11
  } wlen_e;

  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WL16:    return 16;
      WL20:    return 20;
      WL24:    return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] w,
                                                    input logic [1:0] code);
    case (wlen_e'(code))
      WL16:    return {{16{w[15]}}, w[15:0]};
      WL20:    return {{12{w[19]}}, w[19:0]};
      WL24:    return {{8{w[23]}}, w[23:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/rj_rx_sync.sv
module rj_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d[i]};
      end
      assign q[i] = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rj_rx_edge.sv
module rj_rx_edge (
  input  logic clk,
  input  logic clr,
  input  logic inv,
  input  logic bclk_s,
  input  logic wclk_s,
  input  logic data_s,
  output logic stb,
  output logic wclk_o,
  output logic data_o
);

  logic cur;
  logic prev;

  assign cur = bclk_s ^ inv;

  always_ff @(posedge clk) begin
    if (clr) begin
      prev   <= 1'b1;
      stb    <= 1'b0;
      wclk_o <= 1'b0;
      data_o <= 1'b0;
    end else begin
      prev   <= cur;
      stb    <= cur & ~prev;
      wclk_o <= wclk_s;
      data_o <= data_s;
    end
  end

endmodule

// File: rtl/rj_rx_frame.sv
module rj_rx_frame #(
  parameter int SR_W  = 32,
  parameter int CNT_W = 9,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             stb,
  input  logic             wclk,
  input  logic             data,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CNT_W-1:0] min_len,
  output logic             cap_left,
  output logic             cap_right,
  output logic [SR_W-1:0]  cap_word,
  output logic             frame_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             seen;
  logic             wclk_q;
  logic             pend;
  logic             pend_right;
  logic             frame_open;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] frm_cnt;
  logic [SR_W-1:0]  shreg;

  logic             bnd;
  logic [CNT_W-1:0] idx_n;
  logic             act_right;
  logic             hit;

  always_comb begin
    bnd       = seen && (wclk != wclk_q);
    idx_n     = bnd ? '0 : ((idx == CNT_MAX) ? idx : idx + 1'b1);
    act_right = bnd ? wclk : pend_right;
    hit       = seen && (bnd || pend) && (idx_n == CNT_W'(ofs));
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      seen       <= 1'b0;
      wclk_q     <= 1'b0;
      pend       <= 1'b0;
      pend_right <= 1'b0;
      frame_open <= 1'b0;
      idx        <= '0;
      frm_cnt    <= '0;
      shreg      <= '0;
      cap_left   <= 1'b0;
      cap_right  <= 1'b0;
      cap_word   <= '0;
      frame_err  <= 1'b0;
    end else begin
      cap_left  <= 1'b0;
      cap_right <= 1'b0;
      if (stb) begin
        shreg  <= {shreg[SR_W-2:0], data};
        wclk_q <= wclk;
        seen   <= 1'b1;
        if (seen) begin
          idx <= idx_n;
          if (bnd) begin
            pend       <= 1'b1;
            pend_right <= wclk;
          end
          if (hit) begin
            pend      <= 1'b0;
            cap_word  <= shreg;
            cap_left  <= ~act_right;
            cap_right <= act_right;
          end
          if (bnd && wclk) begin
            if (frame_open) frame_err <= (frm_cnt < min_len);
            frm_cnt    <= CNT_W'(1);
            frame_open <= 1'b1;
          end else if (frm_cnt != CNT_MAX) begin
            frm_cnt <= frm_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
  import rj_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9,
  parameter int OFS_W       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_wlen,
  input  logic [OFS_W-1:0]    cfg_offset,
  input  logic                cfg_bclk_inv,
  input  logic                ser_bclk,
  input  logic                ser_wclk,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                out_valid,
  output logic                frame_err
);

  logic                clr;
  logic [2:0]          sync_q;
  logic                stb;
  logic                wclk_e;
  logic                data_e;
  logic [CNT_W-1:0]    min_len;
  logic                cap_left;
  logic                cap_right;
  logic [SAMPLE_W-1:0] cap_word;
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  assign clr     = rst || (cfg_mode != MODE_RJ);
  assign min_len = CNT_W'(2 * wlen_bits(cfg_wlen));

  rj_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_bclk, ser_wclk, ser_data}),
    .q   (sync_q)
  );

  rj_rx_edge u_edge (
    .clk    (clk),
    .clr    (clr),
    .inv    (cfg_bclk_inv),
    .bclk_s (sync_q[2]),
    .wclk_s (sync_q[1]),
    .data_s (sync_q[0]),
    .stb    (stb),
    .wclk_o (wclk_e),
    .data_o (data_e)
  );

  rj_rx_frame #(.SR_W(SAMPLE_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_frame (
    .clk       (clk),
    .clr       (clr),
    .stb       (stb),
    .wclk      (wclk_e),
    .data      (data_e),
    .ofs       (cfg_offset),
    .min_len   (min_len),
    .cap_left  (cap_left),
    .cap_right (cap_right),
    .cap_word  (cap_word),
    .frame_err (frame_err)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      left_hold <= '0;
      have_left <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (cap_left) begin
        left_hold <= sext_word(cap_word, cfg_wlen);
        have_left <= 1'b1;
      end
      if (cap_right && have_left) begin
        out_left  <= left_hold;
        out_right <= sext_word(cap_word, cfg_wlen);
        out_valid <= 1'b1;
        have_left <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk
  import rj_rx_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [1:0]          cfg_mode,
  input logic [1:0]          cfg_wlen,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                out_valid,
  input logic                frame_err
);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && cfg_mode == MODE_RJ && $past(cfg_mode) == MODE_RJ)
      |-> ($stable(out_left) && $stable(out_right)));

  p_valid_needs_mode_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(cfg_mode) == MODE_RJ);

  p_idle_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != MODE_RJ) |=> (!out_valid && !frame_err && out_left == '0 && out_right == '0));

  p_sext_left_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $stable(cfg_wlen)) |-> out_left == sext_word(out_left, cfg_wlen));

  p_sext_right_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $stable(cfg_wlen)) |-> out_right == sext_word(out_right, cfg_wlen));

endmodule

bind rj_audio_rx rj_audio_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_mode  (cfg_mode),
  .cfg_wlen  (cfg_wlen),
  .out_left  (out_left),
  .out_right (out_right),
  .out_valid (out_valid),
  .frame_err (frame_err)
);

// File: tb/rj_audio_rx_bench.sv
`timescale 1ns/1ps
module rj_audio_rx_bench;

  localparam int OFS_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_mode = 2'b00;
  logic [1:0]       cfg_wlen = 2'b00;
  logic [OFS_W-1:0] cfg_offset = '0;
  logic             cfg_bclk_inv = 1'b0;
  logic             ser_bclk = 1'b0;
  logic             ser_wclk = 1'b0;
  logic             ser_data = 1'b0;
  logic [31:0]      out_left;
  logic [31:0]      out_right;
  logic             out_valid;
  logic             frame_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int          nvalid = 0;
  int          multi = 0;
  bit          last_v = 0;
  logic [31:0] got_l [8];
  logic [31:0] got_r [8];
  logic [31:0] val_l [8];
  logic [31:0] val_r [8];

  always #2.5 clk = ~clk;

  rj_audio_rx #(.OFS_W(OFS_W)) u_rj_audio_rx (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_wlen     (cfg_wlen),
    .cfg_offset   (cfg_offset),
    .cfg_bclk_inv (cfg_bclk_inv),
    .ser_bclk     (ser_bclk),
    .ser_wclk     (ser_wclk),
    .ser_data     (ser_data),
    .out_left     (out_left),
    .out_right    (out_right),
    .out_valid    (out_valid),
    .frame_err    (frame_err)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (nvalid < 8) begin
        got_l[nvalid] = out_left;
        got_r[nvalid] = out_right;
      end
      nvalid++;
      if (last_v) multi++;
    end
    last_v = out_valid;
  end

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
  endfunction

  function automatic logic [31:0] expect_ext(input logic [31:0] w, input int n);
    logic signed [31:0] t;
    t = $signed(w << (32 - n));
    return 32'(t >>> (32 - n));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    ser_wclk = w;
    ser_data = d;
    ser_bclk = cfg_bclk_inv;
    repeat (4) @(negedge clk);
    ser_bclk = ~cfg_bclk_inv;
    repeat (3) @(negedge clk);
  endtask

  // Streams n data frames followed by one all-zero frame, half length h bits.
  task automatic stream(input int n, input int wl, input int h, input int k);
    logic [31:0] pr = '0;
    for (int f = 0; f <= n; f++) begin
      logic [31:0] lv = (f < n) ? val_l[f] : '0;
      logic [31:0] rv = (f < n) ? val_r[f] : '0;
      int pl = h - 1 + k;
      int pR = 2 * h - 1 + k;
      for (int p = 0; p < 2 * h; p++) begin
        logic b = 1'b0;
        if (p < k) begin
          if (k - 1 - p < wl) b = pr[k - 1 - p];
        end else if (p <= pl) begin
          if (pl - p < wl) b = lv[pl - p];
        end else begin
          if (pR - p < wl) b = rv[pR - p];
        end
        send_bit(p < h, b);
      end
      pr = rv;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic prep(input logic [1:0] wc, input int k, input logic inv);
    @(negedge clk);
    cfg_mode = 2'b00;
    ser_bclk = inv;
    ser_wclk = 1'b0;
    repeat (6) @(negedge clk);
    cfg_wlen = wc;
    cfg_offset = OFS_W'(k);
    cfg_bclk_inv = inv;
    repeat (4) @(negedge clk);
    cfg_mode = 2'b10;
    repeat (4) @(negedge clk);
    nvalid = 0;
  endtask

  task automatic compare_all(input int n, input int wl, input string req);
    check(nvalid == n, {req, " strobe count"}, 32'(nvalid), 32'(n));
    for (int i = 0; i < n && i < 8; i++) begin
      check(got_l[i] === expect_ext(val_l[i], wl), {req, " left"}, got_l[i],
            expect_ext(val_l[i], wl));
      check(got_r[i] === expect_ext(val_r[i], wl), {req, " right"}, got_r[i],
            expect_ext(val_r[i], wl));
    end
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R8 reset valid", 32'(out_valid), 32'h0);
    check(out_left == '0, "R8 reset left", out_left, 32'h0);
    check(frame_err == 1'b0, "R8 reset err", 32'(frame_err), 32'h0);
  endtask

  // R2 R3 R4: 24-bit words in 32-bit halves, negative left, positive right.
  task automatic t_basic24;
    val_l[0] = 32'h5A81_2345; val_r[0] = 32'hC37E_DCBA;
    val_l[1] = 32'h0000_0001; val_r[1] = 32'hFF80_0000;
    prep(2'b10, 0, 1'b0);
    stream(2, 24, 32, 0);
    compare_all(2, 24, "R2/R3 wl24");
    check(frame_err == 1'b0, "R7 long frame", 32'(frame_err), 32'h0);
  endtask

  // R4 R7: 16-bit words in exactly 16-bit halves (frame equal to 2*WL).
  task automatic t_exact16;
    val_l[0] = 32'h0000_8001; val_r[0] = 32'h0000_7FFE;
    val_l[1] = 32'h1234_ABCD; val_r[1] = 32'h0000_0F0F;
    prep(2'b00, 0, 1'b0);
    stream(2, 16, 16, 0);
    compare_all(2, 16, "R4 wl16");
    check(frame_err == 1'b0, "R7 exact frame", 32'(frame_err), 32'h0);
  endtask

  // R5: 20-bit words, 24-bit halves, offset 3.
  task automatic t_offset20;
    val_l[0] = 32'h000F_FFFF; val_r[0] = 32'h0008_0001;
    val_l[1] = 32'h0004_5678; val_r[1] = 32'h000A_5A5A;
    val_l[2] = 32'h0000_0000; val_r[2] = 32'h0007_FFFF;
    prep(2'b01, 3, 1'b0);
    stream(3, 20, 24, 3);
    compare_all(3, 20, "R5 offset3");
  endtask

  // R6: 32-bit words, inverted bit clock.
  task automatic t_invert32;
    val_l[0] = 32'h8000_0001; val_r[0] = 32'h7FFF_FFFE;
    val_l[1] = 32'hDEAD_BEEF; val_r[1] = 32'h0123_4567;
    prep(2'b11, 0, 1'b1);
    stream(2, 32, 32, 0);
    compare_all(2, 32, "R6 inverted");
  endtask

  // R7: short frames raise the flag, then long frames clear it.
  task automatic t_short;
    for (int i = 0; i < 3; i++) begin
      val_l[i] = 32'h11 * (i + 1); val_r[i] = 32'h22 * (i + 1);
    end
    prep(2'b10, 0, 1'b0);
    stream(3, 24, 20, 0);
    check(frame_err == 1'b1, "R7 short frame", 32'(frame_err), 32'h1);
    stream(3, 24, 32, 0);
    check(frame_err == 1'b0, "R7 cleared by long frame", 32'(frame_err), 32'h0);
  endtask

  // R1 R8: non-RJ mode code produces nothing and clears the outputs.
  task automatic t_idle;
    val_l[0] = 32'h0012_3456; val_r[0] = 32'h0065_4321;
    val_l[1] = 32'h0011_1111; val_r[1] = 32'h0022_2222;
    prep(2'b10, 0, 1'b0);
    @(negedge clk);
    cfg_mode = 2'b01;
    nvalid = 0;
    stream(2, 24, 32, 0);
    check(nvalid == 0, "R1 idle strobes", 32'(nvalid), 32'h0);
    check(out_left == '0, "R8 idle left", out_left, 32'h0);
    check(out_right == '0, "R8 idle right", out_right, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    cfg_mode = 2'b10;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic24();
    t_exact16();
    t_offset20();
    t_invert32();
    t_short();
    t_idle();
    check(multi == 0, "R9 strobe width", 32'(multi), 32'h0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule